// File: doc/BRIEF.md
# Adaptive Threshold Proximity Comparator

This block turns a stream of unsigned conversion results into a single active-high proximity flag. Each time a new result arrives with its valid strobe, the block compares it against a threshold and records the outcome. In fixed operation the threshold is a programmed constant. In adaptive operation the threshold comes from a baseline that tracks the input through a shift-based recursive average, so slow environmental drift is absorbed and fast excursions are flagged.

The baseline time constant is a power of two chosen by a four-bit exponent, which covers time constants from 2 to 65,536 samples. In adaptive operation a symmetric sensitivity band around the baseline gives an upper and a lower threshold. The comparison can flag rises, falls, presence inside the band, or presence outside it. The integer part of the baseline is always available on an output so that a host can read it.

Top module: `prox_thresh_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears `detect` to 0 and `baseline` to 0 from the next cycle, and the block then treats the next valid sample as its first.
- R2: `detect` and `baseline` change only in the cycle after a rising edge with `smp_valid` high. Between strobes both hold their values whatever the other inputs do.
- R3: The first valid sample after reset loads the average with that sample, so `baseline` equals it. That sample is also compared against itself as its baseline.
- R4: The average is a 28-bit accumulator holding 12 integer and 16 fractional bits. On each later valid sample x it becomes acc + floor((x·2^16 − acc) / 2^(settle_exp+1)), where `settle_exp` is 0 to 15. `baseline` is the top 12 bits of acc.
- R5: A sample is compared against the baseline that exists before that sample updates the average.
- R6: In adaptive operation (`adapt_en`=1) the upper threshold is min(base+`sens_band`, 4095) and the lower threshold is max(base−`sens_band`, 0).
- R7: `cmp_mode`=0 (above): `detect` is 1 when the sample is strictly greater than the upper threshold.
- R8: `cmp_mode`=1 (below): `detect` is 1 when the sample is strictly less than the lower threshold.
- R9: `cmp_mode`=2 (inside), adaptive only: `detect` is 1 when lower ≤ sample ≤ upper.
- R10: `cmp_mode`=3 (outside), adaptive only: `detect` is 1 when sample < lower or sample > upper.
- R11: In fixed operation (`adapt_en`=0) both thresholds equal `fix_level`. `cmp_mode` bit 0 selects above (0) or below (1), and bit 1 is ignored.
- R12: In adaptive operation a slow ramp never sets `detect`, while a step larger than the band does. In the above mode, a ramp of 2 codes per sample with `settle_exp`=0 and a band of 20 stays undetected, and a +100 step is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Strobe marking a new conversion result |
| smp_data | input | 12 | Unsigned conversion result |
| adapt_en | input | 1 | 1 = adaptive baseline, 0 = fixed threshold |
| cmp_mode | input | 2 | 0 above, 1 below, 2 inside band, 3 outside band |
| settle_exp | input | 4 | Average shift minus one (time constant 2^(settle_exp+1)) |
| sens_band | input | 12 | Half-width of the adaptive band |
| fix_level | input | 12 | Threshold used in fixed operation |
| detect | output | 1 | Registered proximity flag, active high |
| baseline | output | 12 | Integer part of the running average |

## Verification
The hardest condition to reach from the ports is the longest time constant. There, a single step must move the accumulator only through its fractional bits while the integer baseline creeps by one code at a time. The bench preloads zero, sets the largest exponent, and drives full-scale samples repeatedly so that each small increment is checked against an independent accumulator model. Saturated thresholds are reached by preloading the baseline near 0 and near 4095 with a wide band, which makes a wrapped sum or difference flip the flag.

// File: rtl/prox_pkg.sv
package prox_pkg;
   typedef enum logic [1:0] {
      CMP_ABOVE   = 2'd0,
      CMP_BELOW   = 2'd1,
      CMP_INSIDE  = 2'd2,
      CMP_OUTSIDE = 2'd3
   } cmp_mode_e;
endpackage

// File: rtl/prox_avg_filter.sv
module prox_avg_filter #(
   parameter int DATA_W    = 12,
   parameter int FRAC_W    = 16,
   parameter int EXP_W     = 4,
   parameter int MAX_SHIFT = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [EXP_W-1:0]  settle_exp,
   output logic [DATA_W-1:0] base_now,
   output logic [DATA_W-1:0] base_reg
);
   localparam int ACC_W = DATA_W + FRAC_W;

   if (FRAC_W < MAX_SHIFT) begin : g_bad_frac
      $error("FRAC_W must be at least MAX_SHIFT");
   end
   if (MAX_SHIFT > (1 << EXP_W)) begin : g_bad_exp
      $error("EXP_W too narrow for MAX_SHIFT");
   end

   logic [ACC_W-1:0]        acc;
   logic                    primed;
   logic signed [ACC_W:0]   diff;
   logic signed [ACC_W:0]   step_tab [MAX_SHIFT];
   logic signed [ACC_W:0]   step;
   logic signed [ACC_W:0]   sum;

   assign diff = $signed({1'b0, smp_data, {FRAC_W{1'b0}}}) - $signed({1'b0, acc});

   for (genvar g = 0; g < MAX_SHIFT; g++) begin : g_shift
      assign step_tab[g] = diff >>> (g + 1);
   end

   always_comb begin
      step = step_tab[MAX_SHIFT-1];
      for (int i = 0; i < MAX_SHIFT; i++) begin
         if (int'(settle_exp) == i) step = step_tab[i];
      end
   end

   assign sum = $signed({1'b0, acc}) + step;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc    <= '0;
         primed <= 1'b0;
      end else if (smp_valid) begin
         primed <= 1'b1;
         if (!primed) acc <= {smp_data, {FRAC_W{1'b0}}};
         else         acc <= sum[ACC_W-1:0];
      end
   end

   assign base_reg = acc[ACC_W-1:FRAC_W];
   assign base_now = primed ? base_reg : smp_data;
endmodule

// File: rtl/prox_thr_gen.sv
module prox_thr_gen #(
   parameter int DATA_W = 12
) (
   input  logic              adapt_en,
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] sens_band,
   input  logic [DATA_W-1:0] fix_level,
   output logic [DATA_W-1:0] thr_hi,
   output logic [DATA_W-1:0] thr_lo
);
   logic [DATA_W:0]   up_sum;
   logic [DATA_W-1:0] hi_sat;
   logic [DATA_W-1:0] lo_sat;

   assign up_sum = {1'b0, base} + {1'b0, sens_band};
   assign hi_sat = up_sum[DATA_W] ? {DATA_W{1'b1}} : up_sum[DATA_W-1:0];
   assign lo_sat = (sens_band > base) ? '0 : base - sens_band;

   assign thr_hi = adapt_en ? hi_sat : fix_level;
   assign thr_lo = adapt_en ? lo_sat : fix_level;
endmodule

// File: rtl/prox_cmp.sv
module prox_cmp
   import prox_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              adapt_en,
   input  cmp_mode_e         mode,
   input  logic [DATA_W-1:0] smp,
   input  logic [DATA_W-1:0] thr_hi,
   input  logic [DATA_W-1:0] thr_lo,
   output logic              hit
);
   logic over, under;

   assign over  = smp > thr_hi;
   assign under = smp < thr_lo;

   always_comb begin
      if (!adapt_en) begin
         hit = mode[0] ? under : over;
      end else begin
         unique case (mode)
            CMP_ABOVE:   hit = over;
            CMP_BELOW:   hit = under;
            CMP_INSIDE:  hit = !over && !under;
            CMP_OUTSIDE: hit = over || under;
            default:     hit = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/prox_thresh_top.sv
module prox_thresh_top
   import prox_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int FRAC_W    = 16,
   parameter int EXP_W     = 4,
   parameter int MAX_SHIFT = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              adapt_en,
   input  logic [1:0]        cmp_mode,
   input  logic [EXP_W-1:0]  settle_exp,
   input  logic [DATA_W-1:0] sens_band,
   input  logic [DATA_W-1:0] fix_level,
   output logic              detect,
   output logic [DATA_W-1:0] baseline
);
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] base_now;
   logic [DATA_W-1:0] thr_hi, thr_lo;
   logic              hit;
   cmp_mode_e         mode;

   assign mode = cmp_mode_e'(cmp_mode);

   prox_avg_filter #(
      .DATA_W(DATA_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W), .MAX_SHIFT(MAX_SHIFT)
   ) i_avg (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
      .settle_exp(settle_exp), .base_now(base_now), .base_reg(baseline)
   );

   prox_thr_gen #(.DATA_W(DATA_W)) i_thr (
      .adapt_en(adapt_en), .base(base_now), .sens_band(sens_band),
      .fix_level(fix_level), .thr_hi(thr_hi), .thr_lo(thr_lo)
   );

   prox_cmp #(.DATA_W(DATA_W)) i_cmp (
      .adapt_en(adapt_en), .mode(mode), .smp(smp_data),
      .thr_hi(thr_hi), .thr_lo(thr_lo), .hit(hit)
   );

   always_ff @(posedge clk) begin
      if (rst)            detect <= 1'b0;
      else if (smp_valid) detect <= hit;
   end
endmodule

// File: rtl/prox_thresh_chk.sv
module prox_thresh_chk #(
   parameter int DATA_W = 12
) (
   input logic              clk,
   input logic              rst,
   input logic              smp_valid,
   input logic [DATA_W-1:0] smp_data,
   input logic              adapt_en,
   input logic [1:0]        cmp_mode,
   input logic [DATA_W-1:0] fix_level,
   input logic              detect,
   input logic [DATA_W-1:0] baseline
);
   logic seen;
   always_ff @(posedge clk) begin
      if (rst)            seen <= 1'b0;
      else if (smp_valid) seen <= 1'b1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!detect && baseline == '0));

   // R2
   hold_between_chk: assert property (@(posedge clk) disable iff (rst)
      !smp_valid |=> ($stable(detect) && $stable(baseline)));

   // R3
   first_load_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && !seen) |=> (baseline == $past(smp_data)));

   // R4
   toward_sample_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && seen && smp_data >= baseline) |=>
         (baseline >= $past(baseline) && baseline <= $past(smp_data)));

   // R11
   fixed_above_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && !adapt_en && !cmp_mode[0]) |=>
         (detect == ($past(smp_data) > $past(fix_level))));

   // R11
   fixed_below_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && !adapt_en && cmp_mode[0]) |=>
         (detect == ($past(smp_data) < $past(fix_level))));
endmodule

bind prox_thresh_top prox_thresh_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
   .adapt_en(adapt_en), .cmp_mode(cmp_mode), .fix_level(fix_level),
   .detect(detect), .baseline(baseline)
);

// File: tb/test_prox_thresh_top.sv
module test_prox_thresh_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_data = '0;
   logic        adapt_en = 1'b0;
   logic [1:0]  cmp_mode = 2'd0;
   logic [3:0]  settle_exp = 4'd0;
   logic [11:0] sens_band = '0;
   logic [11:0] fix_level = '0;
   logic        detect;
   logic [11:0] baseline;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [27:0] m_acc = '0;
   bit          m_primed = 0;
   bit          m_det = 0;

   always #5 clk = ~clk;

   prox_thresh_top i_prox_thresh_top (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
      .adapt_en(adapt_en), .cmp_mode(cmp_mode), .settle_exp(settle_exp),
      .sens_band(sens_band), .fix_level(fix_level),
      .detect(detect), .baseline(baseline)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      smp_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_acc = '0; m_primed = 0; m_det = 0;
   endtask

   // Model derived from R3..R11; returns expected detect.
   task automatic model(input logic [11:0] x);
      logic [11:0] base, hi, lo;
      logic [12:0] s;
      logic signed [28:0] d;
      base = m_primed ? m_acc[27:16] : x;
      s  = {1'b0, base} + {1'b0, sens_band};
      hi = s[12] ? 12'hFFF : s[11:0];
      lo = (sens_band > base) ? 12'd0 : base - sens_band;
      if (!adapt_en) m_det = cmp_mode[0] ? (x < fix_level) : (x > fix_level);
      else case (cmp_mode)
         2'd0: m_det = x > hi;
         2'd1: m_det = x < lo;
         2'd2: m_det = (x >= lo) && (x <= hi);
         default: m_det = (x < lo) || (x > hi);
      endcase
      if (!m_primed) m_acc = {x, 16'h0};
      else begin
         d = $signed({1'b0, x, 16'h0}) - $signed({1'b0, m_acc});
         d = d >>> (int'(settle_exp) + 1);
         m_acc = m_acc + d[27:0];
      end
      m_primed = 1;
   endtask

   task automatic send(input logic [11:0] x, input string req);
      model(x);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = x;
      @(negedge clk);
      smp_valid = 1'b0;
      check({req, " detect"}, {31'd0, detect}, {31'd0, m_det});
      check({req, " baseline"}, {20'd0, baseline}, {20'd0, m_acc[27:16]});
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 detect after reset", {31'd0, detect}, 0);
      check("R1 baseline after reset", {20'd0, baseline}, 0);
   endtask

   task automatic t_preload();
      adapt_en = 1; cmp_mode = 2'd0; sens_band = 12'd0; settle_exp = 4'd2;
      send(12'd1234, "R3 first sample");
      check("R3 preload value", {20'd0, baseline}, 1234);
      send(12'd1300, "R4 R5 second sample");
   endtask

   task automatic t_hold();
      logic d0;
      logic [11:0] b0;
      d0 = detect; b0 = baseline;
      @(negedge clk);
      smp_data = 12'd4000; cmp_mode = 2'd3; adapt_en = 0; fix_level = 12'd1;
      repeat (3) @(negedge clk);
      check("R2 detect held", {31'd0, detect}, {31'd0, d0});
      check("R2 baseline held", {20'd0, baseline}, {20'd0, b0});
   endtask

   task automatic t_fixed();
      do_reset();
      adapt_en = 0; fix_level = 12'd2000;
      cmp_mode = 2'd0; send(12'd2001, "R11 fixed above hit");
      check("R11 above hit", {31'd0, detect}, 1);
      send(12'd2000, "R11 fixed above equal");
      cmp_mode = 2'd2; send(12'd2500, "R11 bit1 ignored above");
      check("R11 bit1 ignored", {31'd0, detect}, 1);
      cmp_mode = 2'd1; send(12'd1999, "R11 fixed below hit");
      cmp_mode = 2'd3; send(12'd2000, "R11 fixed below equal");
   endtask

   task automatic t_adaptive_modes();
      do_reset();
      adapt_en = 1; settle_exp = 4'd3; sens_band = 12'd50;
      cmp_mode = 2'd0; send(12'd1000, "R3 preload");
      send(12'd1051, "R7 above hit");
      send(12'd1020, "R7 above miss");
      cmp_mode = 2'd1; send(12'd900, "R8 below hit");
      send(12'd1000, "R8 below miss");
      cmp_mode = 2'd2; send(12'd1010, "R9 inside hit");
      send(12'd3000, "R9 inside miss");
      cmp_mode = 2'd3; send(12'd100, "R10 outside hit");
      send(12'd1000, "R10 outside miss");
   endtask

   task automatic t_saturation();
      do_reset();
      adapt_en = 1; settle_exp = 4'd15; sens_band = 12'd100;
      cmp_mode = 2'd0; send(12'd4090, "R6 preload high");
      send(12'd4095, "R6 upper saturates");
      check("R6 no wrap high", {31'd0, detect}, 0);
      do_reset();
      cmp_mode = 2'd1; send(12'd5, "R6 preload low");
      send(12'd0, "R6 lower saturates");
      check("R6 no wrap low", {31'd0, detect}, 0);
   endtask

   task automatic t_drift();
      int hits = 0;
      do_reset();
      adapt_en = 1; settle_exp = 4'd0; sens_band = 12'd20; cmp_mode = 2'd0;
      send(12'd1000, "R12 preload");
      for (int i = 1; i <= 50; i++) begin
         send(12'(1000 + 2 * i), "R12 ramp");
         if (detect) hits++;
      end
      check("R12 ramp never detects", hits, 0);
      send(12'd1200, "R12 fast step");
      check("R12 step detects", {31'd0, detect}, 1);
   endtask

   task automatic t_long_const();
      do_reset();
      adapt_en = 1; settle_exp = 4'd15; sens_band = 12'd10; cmp_mode = 2'd2;
      send(12'd0, "R4 preload zero");
      for (int i = 0; i < 20; i++) send(12'd4095, "R4 max shift");
      settle_exp = 4'd5;
      for (int i = 0; i < 10; i++) send(12'd300, "R4 mid shift");
   endtask

   initial begin
      t_reset();
      t_preload();
      t_hold();
      t_fixed();
      t_adaptive_modes();
      t_saturation();
      t_drift();
      t_long_const();
      do_reset();
      check("R1 reset mid run detect", {31'd0, detect}, 0);
      check("R1 reset mid run baseline", {20'd0, baseline}, 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule